// File: doc/BRIEF.md
# Two-Way Set-Associative Instruction Cache

This block is a read-only instruction cache placed between a processor's instruction fetch port and a slower backing store that is 16 bits wide. The requester presents a 32-bit word read on a memory-mapped slave port that addresses words. The cache stalls the requester with a wait signal until the word is ready. Each lookup compares the tags of both ways of the selected set. On a hit the word is returned with no traffic to the backing store.

On a miss the cache sends a one-cycle line request to a separate fill engine. The engine returns the 64-byte line as 32 halfwords. The cache packs each pair of halfwords into a 32-bit word and writes the word into line storage. It then writes the tag, marks the way valid and most recently used, and answers the read from the new line.

Replacement keeps one recency bit per way. Touching a way, by a hit or by a fill, sets that way's bit and clears the bit of the other way in the same set. Tag and line storage each take at most one write per cycle, so both can map onto block RAM.

Top module: `icache_top`

## Requirements
- R1: After reset every way of every set is invalid with a clear recency bit. While no read is presented, `rd_wait` is 0 and `fill_req` is 0.
- R2: `rd_wait` is 1 in the same cycle that `rd_req` is first presented. It stays 1 until the cycle in which `rd_data` carries the requested word. In that cycle it is 0.
- R3: On a hit, `rd_wait` is high for exactly two cycles: the presentation cycle and one lookup cycle. `fill_req` is not asserted during the access.
- R4: On a miss, exactly one `fill_req` pulse is issued. `fill_line` equals `rd_addr[22:4]`. The read is answered only after all 32 halfword beats of the line have been accepted.
- R5: Beats are consumed in order. Beat 2k is bits [15:0] and beat 2k+1 is bits [31:16] of line word k. Word k holds the word address `{fill_line, k[3:0]}`.
- R6: Installing a line writes the tag of the victim way, sets its valid bit and its recency bit, and clears the recency bit of the other way in the set.
- R7: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid. If both ways are valid, the victim is the way whose recency bit is clear, with way 0 winning ties.
- R8: A hit sets the recency bit of the hit way and clears that of the other way. This makes the other way the next victim.
- R9: Two lines with different tags in the same set are held at once, and both later hit. At most one way hits on any lookup.
- R10: A third tag in a full set evicts the least recently touched line. The other line stays resident and still hits.
- R11: A fill into one set does not disturb lines held in other sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, held until `rd_wait` is seen low |
| rd_addr | input | 23 | Word address of the read |
| rd_wait | output | 1 | Stall; when low with `rd_req` high, `rd_data` is valid |
| rd_data | output | 32 | Read data |
| fill_req | output | 1 | One-cycle pulse requesting a line from the fill engine |
| fill_line | output | 19 | Line number (word address bits 22:4) to fetch |
| fill_beat_valid | input | 1 | Halfword beat from the fill engine is valid |
| fill_beat_data | input | 16 | Halfword beat data |

## Verification
The embedded assertions check these properties on every cycle:
- A new request is stalled at once.
- At most one way hits.
- A fill request comes only from a missed lookup, and never follows a hit.
- The answer after a fill comes only once the last beat is packed.
- Each fill or hit leaves the set's recency bits one-hot on the touched way, with the installed way valid.

Only the directed scenarios can show the following:
- The returned words match a behavioural memory, including halfword order.
- Hit latency is exactly one lookup cycle.
- Victim selection follows the usage history across conflicting tags.
- The surviving line still hits after an eviction.
- Sets stay independent.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int WORD_ADDR_W = 23;
    localparam int BYTE_ADDR_W = 32;
    localparam int DATA_W      = 32;
    localparam int HALF_W      = 16;
    localparam int SETS        = 32;
    localparam int LINE_WORDS  = 16;
    localparam int NWAYS       = 2;

    localparam int SET_W       = $clog2(SETS);
    localparam int OFS_W       = $clog2(LINE_WORDS);
    localparam int WAY_W       = $clog2(NWAYS);
    localparam int TAG_W       = BYTE_ADDR_W - 2 - OFS_W - SET_W;
    localparam int LINE_ADDR_W = WORD_ADDR_W - OFS_W;
    localparam int BEATS       = LINE_WORDS * DATA_W / HALF_W;
    localparam int BEAT_W      = $clog2(BEATS);
    localparam int DATA_DEPTH  = NWAYS * SETS * LINE_WORDS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_REREAD,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] set;
        logic [OFS_W-1:0] ofs;
    } req_addr_t;

    // Word address zero-extended to the full word space, split into fields.
    function automatic req_addr_t split_addr(input logic [WORD_ADDR_W-1:0] a);
        return req_addr_t'({{(BYTE_ADDR_W - 2 - WORD_ADDR_W){1'b0}}, a});
    endfunction

    // Victim: an invalid way first (way 0 first), then the way not recently used.
    function automatic logic pick_victim(input logic [1:0] v, input logic [1:0] u);
        if (!v[0])      return 1'b0;
        else if (!v[1]) return 1'b1;
        else if (!u[0]) return 1'b0;
        else if (!u[1]) return 1'b1;
        else            return 1'b0;
    endfunction

endpackage

// File: rtl/icache_sram.sv
module icache_sram #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/icache_repl.sv
module icache_repl
    import icache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    input  logic [SET_W-1:0] wr_set,
    input  logic             touch_en,
    input  logic             install_en,
    input  logic             way,
    output logic [1:0]       valid,
    output logic [1:0]       used
);
    logic [1:0] valid_q [SETS];
    logic [1:0] used_q  [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                used_q[s]  <= '0;
            end
        end else begin
            if (touch_en || install_en)
                used_q[wr_set] <= way ? 2'b10 : 2'b01;
            if (install_en)
                valid_q[wr_set][way] <= 1'b1;
        end
    end

    assign valid = valid_q[rd_set];
    assign used  = used_q[rd_set];

    // R6 / R8: the touched way becomes the only recently used one.
    assert_recency_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        (touch_en || install_en) |=>
            (used_q[$past(wr_set)] == ($past(way) ? 2'b10 : 2'b01)));

    // R6: an installed way is valid afterwards.
    assert_install_valid_R6: assert property (@(posedge clk) disable iff (rst)
        install_en |=> valid_q[$past(wr_set)][$past(way)]);
endmodule

// File: rtl/icache_fill_pack.sv
module icache_fill_pack
    import icache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              beat_valid,
    input  logic [HALF_W-1:0] beat_data,
    output logic              word_we,
    output logic [OFS_W-1:0]  word_idx,
    output logic [DATA_W-1:0] word_data,
    output logic              line_done
);
    logic [BEAT_W-1:0] cnt_q;
    logic [HALF_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
            low_q <= '0;
        end else if (beat_valid) begin
            cnt_q <= cnt_q + 1'b1;
            if (!cnt_q[0]) low_q <= beat_data;
        end
    end

    assign word_we   = beat_valid && cnt_q[0];
    assign word_idx  = cnt_q[BEAT_W-1:1];
    assign word_data = {beat_data, low_q};
    assign line_done = word_we && (cnt_q == BEAT_W'(BEATS - 1));
endmodule

// File: rtl/icache_top.sv
module icache_top
    import icache_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_req,
    input  logic [WORD_ADDR_W-1:0] rd_addr,
    output logic                   rd_wait,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   fill_req,
    output logic [LINE_ADDR_W-1:0] fill_line,
    input  logic                   fill_beat_valid,
    input  logic [HALF_W-1:0]      fill_beat_data
);
    localparam int DAW = $clog2(DATA_DEPTH);

    state_e                 state_q;
    logic [WORD_ADDR_W-1:0] addr_q;
    req_addr_t              req_q, req_in;
    logic                   victim_q;
    logic                   fill_req_q;

    logic [TAG_W-1:0] tag_rd [NWAYS];
    logic [NWAYS-1:0] hit;
    logic             hit_any, hit_way;
    logic [1:0]       valid, used;
    logic             word_we, line_done;
    logic [OFS_W-1:0] word_idx;
    logic [DATA_W-1:0] word_data;
    logic             rd_way;

    assign req_in = split_addr(rd_addr);
    assign req_q  = split_addr(addr_q);

    // Tag storage, one RAM per way, written only when a line is installed.
    for (genvar w = 0; w < NWAYS; w++) begin : g_tag
        icache_sram #(.W(TAG_W), .DEPTH(SETS)) u_tag (
            .clk  (clk),
            .we   (line_done && (victim_q == WAY_W'(w))),
            .waddr(req_q.set),
            .wdata(req_q.tag),
            .raddr(req_in.set),
            .rdata(tag_rd[w])
        );
        assign hit[w] = valid[w] && (tag_rd[w] == req_q.tag);
    end

    assign hit_any = |hit;
    assign hit_way = hit[1];

    icache_repl u_repl (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (req_q.set),
        .wr_set    (req_q.set),
        .touch_en  (state_q == ST_LOOKUP && hit_any),
        .install_en(line_done),
        .way       ((state_q == ST_LOOKUP) ? hit_way : victim_q),
        .valid     (valid),
        .used      (used)
    );

    icache_fill_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .start     (state_q == ST_LOOKUP),
        .beat_valid(fill_beat_valid),
        .beat_data (fill_beat_data),
        .word_we   (word_we),
        .word_idx  (word_idx),
        .word_data (word_data),
        .line_done (line_done)
    );

    assign rd_way = (state_q == ST_LOOKUP) ? hit_way : victim_q;

    icache_sram #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data (
        .clk  (clk),
        .we   (word_we && state_q == ST_FILL),
        .waddr(DAW'({victim_q, req_q.set, word_idx})),
        .wdata(word_data),
        .raddr(DAW'({rd_way, req_q.set, req_q.ofs})),
        .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            victim_q   <= 1'b0;
            fill_req_q <= 1'b0;
        end else begin
            fill_req_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (rd_req) begin
                    addr_q  <= rd_addr;
                    state_q <= ST_LOOKUP;
                end
                ST_LOOKUP: if (hit_any) begin
                    state_q <= ST_RESP;
                end else begin
                    victim_q   <= pick_victim(valid, used);
                    fill_req_q <= 1'b1;
                    state_q    <= ST_FILL;
                end
                ST_FILL:   if (line_done) state_q <= ST_REREAD;
                ST_REREAD: state_q <= ST_RESP;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_wait   = (state_q == ST_IDLE) ? rd_req : (state_q != ST_RESP);
    assign fill_req  = fill_req_q;
    assign fill_line = addr_q[WORD_ADDR_W-1:OFS_W];

    // R2: a freshly presented request is stalled at once.
    assert_stall_new_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_req) |-> rd_wait);

    // R9: never more than one way hits.
    assert_single_hit_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP) |-> $onehot0(hit));

    // R3: a hit never triggers a fill.
    assert_no_fill_on_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && hit_any) |=> !fill_req);

    // R4: a fill request only follows a missed lookup.
    assert_fill_from_miss_R4: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> ($past(state_q) == ST_LOOKUP && !$past(hit_any)));

    // R4: the re-read after a fill only happens once the last beat is packed.
    assert_answer_after_line_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REREAD) |-> $past(line_done));
endmodule

// File: tb/icache_top_tb.sv
module icache_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [22:0] rd_addr = '0;
    logic        rd_wait;
    logic [31:0] rd_data;
    logic        fill_req;
    logic [18:0] fill_line;
    logic        fill_beat_valid = 1'b0;
    logic [15:0] fill_beat_data = '0;

    int checks = 0;
    int errors = 0;
    int fills  = 0;
    logic [18:0] last_line = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    icache_top u_dut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_wait(rd_wait), .rd_data(rd_data), .fill_req(fill_req),
        .fill_line(fill_line), .fill_beat_valid(fill_beat_valid),
        .fill_beat_data(fill_beat_data)
    );

    function automatic logic [15:0] mem_hw(input logic [23:0] a);
        return 16'(a * 24'h9E37) ^ 16'(a >> 5) ^ 16'h5A5A;
    endfunction

    function automatic logic [31:0] mem_word(input logic [22:0] a);
        return {mem_hw({a, 1'b1}), mem_hw({a, 1'b0})};
    endfunction

    function automatic logic [22:0] mk(input int tag, input int set, input int ofs);
        return {14'(tag), 5'(set), 4'(ofs)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Fill engine model: serves a line from the behavioural memory, with gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                fills++;
                last_line = fill_line;
                for (int b = 0; b < 32; b++) begin
                    @(negedge clk);
                    if (b % 7 == 3) begin
                        fill_beat_valid = 1'b0;
                        @(negedge clk);
                    end
                    fill_beat_valid = 1'b1;
                    fill_beat_data  = mem_hw({last_line, 5'(b)});
                end
                @(negedge clk);
                fill_beat_valid = 1'b0;
            end
        end
    end

    // One read transaction; checks stall, data, latency and fill traffic.
    task automatic do_read(input logic [22:0] a, input bit exp_miss, input string req);
        int f0 = fills;
        int waits = 0;
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = a;
        #1;
        check(rd_wait === 1'b1, "R2", "stall on presentation", 32'(rd_wait), 32'd1);
        while (1) begin
            @(negedge clk);
            if (!rd_wait || waits > 400) break;
            waits++;
        end
        check(rd_data === mem_word(a), req, "read data", rd_data, mem_word(a));
        check((fills - f0) == int'(exp_miss), req, exp_miss ? "one fill on miss" : "no fill on hit",
              32'(fills - f0), 32'(exp_miss));
        if (exp_miss)
            check(last_line === a[22:4], "R4", "fill line address", 32'(last_line), 32'(a[22:4]));
        else
            check(waits == 1, "R3", "hit latency", 32'(waits), 32'd1);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(rd_wait === 1'b0, "R1", "idle wait after reset", 32'(rd_wait), 32'd0);
        check(fill_req === 1'b0, "R1", "no fill after reset", 32'(fill_req), 32'd0);
    endtask

    task automatic t_cold_miss_and_hits;
        do_read(mk(7, 3, 5), 1, "R4");
        do_read(mk(7, 3, 5), 0, "R3");
        do_read(mk(7, 3, 0), 0, "R5");
        do_read(mk(7, 3, 15), 0, "R5");
        do_read(mk(7, 3, 9), 0, "R6");
    endtask

    task automatic t_conflict;
        do_read(mk(200, 3, 2), 1, "R7");
        do_read(mk(7, 3, 1), 0, "R9");
        do_read(mk(200, 3, 14), 0, "R9");
    endtask

    task automatic t_evict;
        do_read(mk(7, 3, 4), 0, "R8");
        do_read(mk(9000, 3, 6), 1, "R10");
        do_read(mk(7, 3, 8), 0, "R10");
        do_read(mk(200, 3, 3), 1, "R10");
        do_read(mk(7, 3, 12), 0, "R8");
        do_read(mk(9000, 3, 6), 1, "R8");
    endtask

    task automatic t_other_set;
        do_read(mk(9000, 4, 11), 1, "R11");
        do_read(mk(7, 3, 7), 0, "R11");
        do_read(mk(9000, 3, 0), 0, "R11");
        do_read(mk(9000, 4, 1), 0, "R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold_miss_and_hits();
        t_conflict();
        t_evict();
        t_other_set();
        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule